// File: doc/BRIEF.md
# Inbound Interrupt Write Router

This block takes posted memory writes arriving from two downstream ports, stores each one in a shared eight-entry inbound buffer, and then sorts the writes at the buffer head. A write whose upper address bits fall inside the interrupt address window leaves through the interrupt-message output, which faces the processor bus. Every other write leaves through the ordinary memory-write output. An interrupt write is not recognised as one until it has been stored. At the edge it is treated exactly like any other write: it is accepted while the buffer has space, and it is told to retry while the buffer is full.

The second port carries a qualifier bit that marks a write as having PCI semantics. Only writes that carry this mark can be promoted to interrupt messages. A window write from the second port without the mark goes to the memory output. Writes from the first port always qualify. The two outputs share one payload bus, and each output has its own valid/ready pair. The buffer drains strictly in arrival order.

Top module: `inbound_irq_router`

## Requirements
- R1: After reset, both outputs are not valid, and no port sees ready or retry while its valid is low.
- R2: A port that presents a valid request while the buffer holds fewer than 8 writes sees its ready high in that same cycle, and the write is stored.
- R3: When both ports present a valid request in the same cycle and the buffer is not full, port 0 is accepted. Port 1 then sees neither ready nor retry and must keep its request up.
- R4: A valid request that arrives while 8 writes are stored sees retry high and ready low for that cycle, and the write is discarded. Draining afterwards yields only the 8 stored writes.
- R5: Writes leave the buffer in the order in which they were accepted.
- R6: A write from port 0 whose address bits 31:20 equal 0xFEE is presented on the interrupt output (intValid). All other port 0 writes are presented on the memory output (memValid).
- R7: A write from port 1 goes to the interrupt output only if its address bits 31:20 equal 0xFEE and in1PciSem was 1 when it was accepted. Otherwise it goes to the memory output.
- R8: While the head write waits on an output whose ready is low, that output stays valid, the other output stays not valid, and the payload is stable.
- R9: The payload shows the accepted address, data and source id unchanged, and outPort is 0 for port 0 and 1 for port 1.
- R10: The buffer stores exactly 8 writes before it starts answering with retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| in0Valid | input | 1 | Port 0 write request |
| in0Addr | input | 32 | Port 0 write address |
| in0Data | input | 32 | Port 0 write data |
| in0Src | input | 8 | Port 0 source id |
| in0Ready | output | 1 | Port 0 write accepted this cycle |
| in0Retry | output | 1 | Port 0 write refused because the buffer is full |
| in1Valid | input | 1 | Port 1 write request |
| in1Addr | input | 32 | Port 1 write address |
| in1Data | input | 32 | Port 1 write data |
| in1Src | input | 8 | Port 1 source id |
| in1PciSem | input | 1 | Port 1 write has PCI semantics (may become an interrupt) |
| in1Ready | output | 1 | Port 1 write accepted this cycle |
| in1Retry | output | 1 | Port 1 write refused because the buffer is full |
| intValid | output | 1 | Head write is an interrupt message |
| intReady | input | 1 | Interrupt output accepts the head |
| memValid | output | 1 | Head write is an ordinary memory write |
| memReady | input | 1 | Memory output accepts the head |
| outAddr | output | 32 | Head write address |
| outData | output | 32 | Head write data |
| outSrc | output | 8 | Head write source id |
| outPort | output | 1 | Port the head write arrived on |

## Verification
The hardest situation to reach from the ports is a request that meets a completely full buffer. In that case the write must be refused and must leave no trace, and the two ports must also collide in the same cycle. To reach it, the bench fills the buffer with eight accepted writes from both ports while holding both output readies low. It then raises both valids and checks for retry. Finally it drains the buffer and confirms that exactly the eight accepted writes come out, in order. The routing decision is swept over both ports, both qualifier values and addresses just inside and just outside the window edges.

// File: rtl/irw_pkg.sv
package irw_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;      // store the selected port's write
    logic pushPort;  // 0: port 0, 1: port 1
    logic pop;       // retire the head entry
  } irwStrobe_t;

  typedef enum logic {
    ROUTE_MEM = 1'b0,
    ROUTE_INT = 1'b1
  } irwRoute_t;

endpackage

// File: rtl/irw_datapath.sv
module irw_datapath
  import irw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 8,
  parameter int DEPTH    = 8,
  parameter int WIN_W    = 12,
  parameter logic [WIN_W-1:0] WIN_BASE = 12'hFEE
) (
  input  logic              clk,
  input  logic              rstN,
  input  irwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] in0Addr,
  input  logic [DATA_W-1:0] in0Data,
  input  logic [SRC_W-1:0]  in0Src,
  input  logic [ADDR_W-1:0] in1Addr,
  input  logic [DATA_W-1:0] in1Data,
  input  logic [SRC_W-1:0]  in1Src,
  input  logic              in1PciSem,
  output irwRoute_t         headRoute,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic [SRC_W-1:0]  outSrc,
  output logic              outPort
);

  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENTRY_W = ADDR_W + DATA_W + SRC_W + 2;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // Entry layout: {port, qualifies, src, data, addr}
  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [ENTRY_W-1:0] inEntry;
  logic [ENTRY_W-1:0] headEntry;
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic               headQual;
  logic [ADDR_W-1:0]  headAddr;

  // Port 0 writes always qualify; port 1 needs the PCI-semantics mark.
  always_comb begin
    if (strobe.pushPort)
      inEntry = {1'b1, in1PciSem, in1Src, in1Data, in1Addr};
    else
      inEntry = {1'b0, 1'b1, in0Src, in0Data, in0Addr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == PTR_W'(g)) slots[g] <= inEntry;
    end
  end

  assign headEntry = slots[rdPtr];
  assign headAddr  = headEntry[ADDR_W-1:0];
  assign outAddr   = headAddr;
  assign outData   = headEntry[ADDR_W +: DATA_W];
  assign outSrc    = headEntry[ADDR_W+DATA_W +: SRC_W];
  assign headQual  = headEntry[ENTRY_W-2];
  assign outPort   = headEntry[ENTRY_W-1];

  // Decode happens on the stored entry, after posting
  always_comb begin
    if (headQual && headAddr[ADDR_W-1 -: WIN_W] == WIN_BASE)
      headRoute = ROUTE_INT;
    else
      headRoute = ROUTE_MEM;
  end

endmodule

// File: rtl/irw_control.sv
module irw_control
  import irw_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       in0Valid,
  input  logic       in1Valid,
  input  irwRoute_t  headRoute,
  input  logic       intReady,
  input  logic       memReady,
  output logic       in0Ready,
  output logic       in0Retry,
  output logic       in1Ready,
  output logic       in1Retry,
  output logic       intValid,
  output logic       memValid,
  output irwStrobe_t strobe
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             full;
  logic             empty;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  // Fixed priority: port 0 first
  assign in0Ready = in0Valid && !full;
  assign in1Ready = in1Valid && !in0Valid && !full;
  assign in0Retry = in0Valid && full;
  assign in1Retry = in1Valid && full;

  assign intValid = !empty && headRoute == ROUTE_INT;
  assign memValid = !empty && headRoute == ROUTE_MEM;

  always_comb begin
    strobe          = '0;
    strobe.push     = in0Ready || in1Ready;
    strobe.pushPort = !in0Valid;
    strobe.pop      = (intValid && intReady) || (memValid && memReady);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/inbound_irq_router.sv
module inbound_irq_router
  import irw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 8,
  parameter int DEPTH  = 8,
  parameter int WIN_W  = 12,
  parameter logic [WIN_W-1:0] WIN_BASE = 12'hFEE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              in0Valid,
  input  logic [ADDR_W-1:0] in0Addr,
  input  logic [DATA_W-1:0] in0Data,
  input  logic [SRC_W-1:0]  in0Src,
  output logic              in0Ready,
  output logic              in0Retry,
  input  logic              in1Valid,
  input  logic [ADDR_W-1:0] in1Addr,
  input  logic [DATA_W-1:0] in1Data,
  input  logic [SRC_W-1:0]  in1Src,
  input  logic              in1PciSem,
  output logic              in1Ready,
  output logic              in1Retry,
  output logic              intValid,
  input  logic              intReady,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic [SRC_W-1:0]  outSrc,
  output logic              outPort
);

  irwStrobe_t strobe;
  irwRoute_t  headRoute;

  irw_control #(.DEPTH(DEPTH)) u_control (
    .clk(clk), .rstN(rstN),
    .in0Valid(in0Valid), .in1Valid(in1Valid),
    .headRoute(headRoute),
    .intReady(intReady), .memReady(memReady),
    .in0Ready(in0Ready), .in0Retry(in0Retry),
    .in1Ready(in1Ready), .in1Retry(in1Retry),
    .intValid(intValid), .memValid(memValid),
    .strobe(strobe)
  );

  irw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W),
    .DEPTH(DEPTH), .WIN_W(WIN_W), .WIN_BASE(WIN_BASE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .in0Addr(in0Addr), .in0Data(in0Data), .in0Src(in0Src),
    .in1Addr(in1Addr), .in1Data(in1Data), .in1Src(in1Src),
    .in1PciSem(in1PciSem),
    .headRoute(headRoute),
    .outAddr(outAddr), .outData(outData), .outSrc(outSrc),
    .outPort(outPort)
  );

endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int WIN_W  = 12,
  parameter logic [WIN_W-1:0] WIN_BASE = 12'hFEE
) (
  input logic              clk,
  input logic              rstN,
  input logic              in0Valid,
  input logic              in0Ready,
  input logic              in0Retry,
  input logic              in1Valid,
  input logic              in1Ready,
  input logic              in1Retry,
  input logic              intValid,
  input logic              intReady,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic [DATA_W-1:0] outData
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  logic [CNT_W-1:0] occ;
  logic acc;
  logic pop;

  assign acc = in0Ready || in1Ready;
  assign pop = (intValid && intReady) || (memValid && memReady);

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else occ <= occ + CNT_W'(acc) - CNT_W'(pop);
  end

  assert_retry_when_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (in0Retry || in1Retry) |-> (occ == CNT_W'(DEPTH) && !in0Ready && !in1Ready));

  assert_accept_when_space_R2: assert property (@(posedge clk) disable iff (!rstN)
    (in0Valid && occ < CNT_W'(DEPTH)) |-> in0Ready);

  assert_port0_priority_R3: assert property (@(posedge clk) disable iff (!rstN)
    (in0Valid && in1Valid) |-> (!in1Ready && (in1Retry == in0Retry)));

  assert_one_output_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(intValid && memValid));

  assert_hold_int_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intValid && !intReady) |=> (intValid && $stable(outAddr) && $stable(outData)));

  assert_hold_mem_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(outAddr) && $stable(outData)));

  assert_int_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    intValid |-> (outAddr[ADDR_W-1 -: WIN_W] == WIN_BASE));

  assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> (!intValid && !memValid));

endmodule

bind inbound_irq_router irw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
  .WIN_W(WIN_W), .WIN_BASE(WIN_BASE)
) u_irw_checker (
  .clk(clk), .rstN(rstN),
  .in0Valid(in0Valid), .in0Ready(in0Ready), .in0Retry(in0Retry),
  .in1Valid(in1Valid), .in1Ready(in1Ready), .in1Retry(in1Retry),
  .intValid(intValid), .intReady(intReady),
  .memValid(memValid), .memReady(memReady),
  .outAddr(outAddr), .outData(outData)
);

// File: tb/test_inbound_irq_router.sv
module test_inbound_irq_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        in0Valid = 1'b0, in1Valid = 1'b0, in1PciSem = 1'b0;
  logic [31:0] in0Addr = '0, in0Data = '0, in1Addr = '0, in1Data = '0;
  logic [7:0]  in0Src = '0, in1Src = '0;
  logic        in0Ready, in0Retry, in1Ready, in1Retry;
  logic        intValid, memValid;
  logic        intReady = 1'b0, memReady = 1'b0;
  logic [31:0] outAddr, outData;
  logic [7:0]  outSrc;
  logic        outPort;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Expected queue
  logic [31:0] qAddr [16];
  logic [31:0] qData [16];
  logic [7:0]  qSrc  [16];
  logic        qPort [16];
  logic        qInt  [16];
  int qHead = 0;
  int qTail = 0;

  always #10 clk = ~clk;

  inbound_irq_router i_inbound_irq_router (
    .clk(clk), .rstN(rstN),
    .in0Valid(in0Valid), .in0Addr(in0Addr), .in0Data(in0Data), .in0Src(in0Src),
    .in0Ready(in0Ready), .in0Retry(in0Retry),
    .in1Valid(in1Valid), .in1Addr(in1Addr), .in1Data(in1Data), .in1Src(in1Src),
    .in1PciSem(in1PciSem), .in1Ready(in1Ready), .in1Retry(in1Retry),
    .intValid(intValid), .intReady(intReady),
    .memValid(memValid), .memReady(memReady),
    .outAddr(outAddr), .outData(outData), .outSrc(outSrc), .outPort(outPort)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expInt(input logic port, input logic sem, input logic [31:0] a);
    return (a[31:20] == 12'hFEE) && (port == 1'b0 || sem);
  endfunction

  task automatic enq(input logic port, input logic sem, input logic [31:0] a,
                     input logic [31:0] d, input logic [7:0] s);
    qAddr[qTail % 16] = a; qData[qTail % 16] = d; qSrc[qTail % 16] = s;
    qPort[qTail % 16] = port; qInt[qTail % 16] = expInt(port, sem, a);
    qTail++;
  endtask

  // Present one write on one port for one cycle
  task automatic pushOne(input logic port, input logic sem, input logic [31:0] a,
                         input logic [31:0] d, input logic [7:0] s,
                         input bit expAcc, input string req);
    @(negedge clk);
    if (port) begin
      in1Valid = 1; in1Addr = a; in1Data = d; in1Src = s; in1PciSem = sem;
    end else begin
      in0Valid = 1; in0Addr = a; in0Data = d; in0Src = s;
    end
    #5;
    if (port) begin
      check(in1Ready == expAcc && in1Retry == !expAcc, req, {in1Ready, in1Retry}, {expAcc, !expAcc});
    end else begin
      check(in0Ready == expAcc && in0Retry == !expAcc, req, {in0Ready, in0Retry}, {expAcc, !expAcc});
    end
    if (expAcc) enq(port, sem, a, d, s);
    @(posedge clk);
    #1;
    in0Valid = 0; in1Valid = 0;
  endtask

  // Retire the head with both readies high and compare against the model
  task automatic popOne(input string req);
    int k;
    k = qHead % 16;
    @(negedge clk);
    intReady = 1; memReady = 1;
    #5;
    check(intValid == qInt[k] && memValid == !qInt[k], req,
          {intValid, memValid}, {qInt[k], !qInt[k]});
    check(outAddr == qAddr[k] && outData == qData[k] && outSrc == qSrc[k] && outPort == qPort[k],
          "R9/R5 payload", {outAddr, outData}, {qAddr[k], qData[k]});
    qHead++;
    @(posedge clk);
    #1;
    intReady = 0; memReady = 0;
  endtask

  task automatic checkEmpty(input string req);
    @(negedge clk);
    #5;
    check(!intValid && !memValid, req, {intValid, memValid}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] addrs [6];
    logic [31:0] holdAddr;
    addrs[0] = 32'hFEE0_0000; addrs[1] = 32'hFEEF_FFFC; addrs[2] = 32'hFEDF_FFFC;
    addrs[3] = 32'hFEF0_0000; addrs[4] = 32'h0000_1000; addrs[5] = 32'h7FEE_0000;

    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    #5;
    // R1: idle after reset
    check(!intValid && !memValid && !in0Ready && !in0Retry && !in1Ready && !in1Retry,
          "R1 reset", {intValid, memValid, in0Ready, in0Retry, in1Ready, in1Retry}, 0);

    // R6/R7/R9: route sweep over port, qualifier and address edges
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int a = 0; a < 6; a++) begin
          pushOne(p[0], s[0], addrs[a], 32'hD000_0000 + 32'(p*100 + s*10 + a),
                  8'(16*p + 4*s + a), 1'b1, "R2 accept");
          popOne(p ? "R7 route port1" : "R6 route port0");
        end
      end
    end
    checkEmpty("R1 idle after sweep");

    // R10/R4: fill to capacity, then both ports hit a full buffer
    for (int i = 0; i < 8; i++) begin
      pushOne(i[0], i[1], (i % 3 == 0) ? 32'hFEE0_1000 + 32'(i) : 32'h2000_0000 + 32'(i),
              32'hA000_0000 + 32'(i), 8'(i), 1'b1, "R10 fill accepted");
    end
    @(negedge clk);
    in0Valid = 1; in0Addr = 32'hFEE0_BAD0; in1Valid = 1; in1Addr = 32'h3000_0BAD;
    #5;
    check(in0Retry && in1Retry && !in0Ready && !in1Ready, "R4 retry when full",
          {in0Retry, in1Retry, in0Ready, in1Ready}, 4'b1100);
    @(posedge clk);
    #1 in0Valid = 0; in1Valid = 0;
    for (int i = 0; i < 8; i++) popOne("R5 order after fill");
    checkEmpty("R4 refused write not stored");

    // R3: collision on an empty buffer
    @(negedge clk);
    in0Valid = 1; in0Addr = 32'h4000_0000; in0Data = 32'h11; in0Src = 8'h01;
    in1Valid = 1; in1Addr = 32'hFEE0_0040; in1Data = 32'h22; in1Src = 8'h02; in1PciSem = 1;
    #5;
    check(in0Ready && !in0Retry && !in1Ready && !in1Retry, "R3 port0 priority",
          {in0Ready, in0Retry, in1Ready, in1Retry}, 4'b1000);
    enq(1'b0, 1'b1, 32'h4000_0000, 32'h11, 8'h01);
    @(posedge clk);
    #1 in0Valid = 0;
    #1;
    check(in1Ready && !in1Retry, "R3 port1 follows", {in1Ready, in1Retry}, 2'b10);
    enq(1'b1, 1'b1, 32'hFEE0_0040, 32'h22, 8'h02);
    @(posedge clk);
    #1 in1Valid = 0;
    popOne("R3 first is port0");
    popOne("R3 then port1");

    // R8: stall on the interrupt output
    pushOne(1'b0, 1'b1, 32'hFEE1_2340, 32'h55, 8'h05, 1'b1, "R2 accept");
    pushOne(1'b1, 1'b0, 32'hFEE0_0080, 32'h66, 8'h06, 1'b1, "R2 accept");
    holdAddr = 32'hFEE1_2340;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      memReady = 1; intReady = 0;
      #5;
      check(intValid && !memValid && outAddr == holdAddr, "R8 stall holds",
            {intValid, memValid, outAddr}, {2'b10, holdAddr});
    end
    #1 memReady = 0;
    popOne("R6 after stall");
    popOne("R7 unqualified window write to memory");
    checkEmpty("R1 idle at end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule